// File: doc/BRIEF.md
# Paged Segment Address Translator

This block maps 32-bit virtual addresses onto 32-bit physical addresses for a memory scheme that uses segments made of pages. A virtual address carries a section number, a segment number, a page number and a byte offset. The translator looks up a small segment descriptor cache and a page descriptor cache. The page entry supplies the physical frame number, and the offset bits pass straight through. Pages are fixed at 2K bytes, so the frame fills physical bits 31..11.

Software fills both caches through a separate write port. A lookup that finds no matching entry reports a miss, so software can walk its tables in memory and refill the entry. A lookup that finds an entry marked not present reports a fault. A page number beyond the segment's last page also reports a fault. A flush input empties both caches in a single cycle.

Requests and results each travel on a valid/ready stream. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The result appears one cycle later and stays frozen while `rsp_ready` is low. While a result is held, `req_ready` stays low. The flush and write controls are plain pins and have no handshake.

Top module: `pst_translator`

## Requirements
- R1: Virtual address fields are section [31:30], segment [29:17], page [16:11] and offset [10:0]. On a hit, `rsp_paddr` is {frame[20:0], offset}.
- R2: The result of a request accepted at edge N is shown with `rsp_valid`=1 after edge N+1. With `rsp_ready` high and no new request, `rsp_valid` then falls.
- R3: `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, every result output holds its value.
- R4: The segment cache is direct-mapped with 8 sets per section. It is indexed by {section, segment[2:0]} and tagged with segment[12:3]. A lookup whose entry is not valid or whose tag differs reports segment miss (code 1, `rsp_miss`=1). The same segment number in another section does not alias.
- R5: A segment entry that is valid but not present reports segment fault (code 2, `rsp_fault`=1).
- R6: A segment entry holds a last-page limit, written on `wr_data[5:0]`. A page number greater than the limit reports bounds fault (code 3, `rsp_fault`=1). A page number equal to the limit is allowed.
- R7: The page cache is direct-mapped and indexed by {section, page[2:0]}. It is tagged with {segment, page[5:3]}. A lookup that finds no valid entry with a matching tag reports page miss (code 4, `rsp_miss`=1).
- R8: A page entry that is valid but not present reports page fault (code 5, `rsp_fault`=1). Otherwise the result is a hit (code 0, `rsp_hit`=1).
- R9: When several conditions apply, they are reported in this order: segment miss, segment fault, bounds, page miss, page fault. Exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is high with `rsp_valid`. `rsp_paddr` is zero unless `rsp_hit` is high.
- R10: A cycle with `flush` high invalidates every entry of both caches. A write in the same cycle is discarded.
- R11: A write with `wr_kind` 0 selects the segment cache and 1 selects the page cache. `wr_vpn` gives {section, segment, page}. A write with `wr_valid`=0 invalidates the entry. A write is seen by requests accepted at later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate both caches |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_vaddr | input | 32 | Virtual address |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address (zero unless hit) |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | Segment or page entry absent from cache |
| rsp_fault | output | 1 | Segment fault, page fault or bounds fault |
| rsp_code | output | 3 | Outcome code 0..5 |
| wr_en | input | 1 | Descriptor write strobe |
| wr_kind | input | 1 | 0 segment cache, 1 page cache |
| wr_vpn | input | 21 | {section, segment, page} of the entry |
| wr_valid | input | 1 | Valid bit written |
| wr_present | input | 1 | Present bit written |
| wr_data | input | 21 | Frame number, or page limit in [5:0] |

## Verification
The bench requests page numbers just below, at and above a segment's limit. An off-by-one comparison would fault a legal last page or translate one page too many. It also sends segments and pages that share a cache index but differ in tag or section, where a design that drops tag bits would report a false hit. Flush is raised in the same cycle as a write, and an entry is invalidated through a write. A design that lets the write win, or ignores the valid bit it writes, would return hits where misses are due. Back-pressure is held across a waiting request. A design that drops the stall or lets the held result change would lose or corrupt a translation.

// File: rtl/pst_pkg.sv
package pst_pkg;
  localparam int ADDR_W  = 32;
  localparam int SEC_W   = 2;
  localparam int SEG_W   = 13;
  localparam int PAGE_W  = 6;
  localparam int OFF_W   = 11;
  localparam int FRAME_W = ADDR_W - OFF_W;
  localparam int VPN_W   = SEC_W + SEG_W + PAGE_W;

  typedef enum logic [2:0] {
    XL_HIT         = 3'd0,
    XL_SEG_MISS    = 3'd1,
    XL_SEG_ABSENT  = 3'd2,
    XL_BOUNDS      = 3'd3,
    XL_PAGE_MISS   = 3'd4,
    XL_PAGE_ABSENT = 3'd5
  } xl_code_e;

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [SEG_W-1:0]  seg;
    logic [PAGE_W-1:0] page;
  } vpn_t;
endpackage

// File: rtl/pst_desc_cache.sv
module pst_desc_cache #(
  parameter int IDX_W  = 5,
  parameter int TAG_W  = 10,
  parameter int DATA_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              wr_valid,
  input  logic              wr_present,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              rd_hit,
  output logic              rd_present,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  vld_q;
  logic [DEPTH-1:0]  prs_q;
  logic [TAG_W-1:0]  tag_q [DEPTH];
  logic [DATA_W-1:0] dat_q [DEPTH];
  logic [DEPTH-1:0]  wsel;

  // one write-select line per entry
  for (genvar e = 0; e < DEPTH; e++) begin : g_sel
    assign wsel[e] = wr_en && !flush && (wr_idx == IDX_W'(e));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      vld_q <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (wsel[e]) vld_q[e] <= wr_valid;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (wsel[e]) begin
        tag_q[e] <= wr_tag;
        prs_q[e] <= wr_present;
        dat_q[e] <= wr_data;
      end
    end
  end

  assign rd_hit     = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_present = prs_q[rd_idx];
  assign rd_data    = dat_q[rd_idx];

  // R10: after a flush cycle no entry can match
  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !rd_hit)
    else $error("flush left a valid entry");
endmodule

// File: rtl/pst_classify.sv
module pst_classify
  import pst_pkg::*;
(
  input  logic              seg_hit,
  input  logic              seg_present,
  input  logic [PAGE_W-1:0] seg_limit,
  input  logic [PAGE_W-1:0] page,
  input  logic              pg_hit,
  input  logic              pg_present,
  output xl_code_e          code
);
  // fixed priority: segment miss, segment absent, bounds, page miss, page absent
  always_comb begin
    if (!seg_hit)                code = XL_SEG_MISS;
    else if (!seg_present)       code = XL_SEG_ABSENT;
    else if (page > seg_limit)   code = XL_BOUNDS;
    else if (!pg_hit)            code = XL_PAGE_MISS;
    else if (!pg_present)        code = XL_PAGE_ABSENT;
    else                         code = XL_HIT;
  end
endmodule

// File: rtl/pst_translator.sv
module pst_translator
  import pst_pkg::*;
#(
  parameter int SETS_PER_SEC = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_vaddr,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [ADDR_W-1:0]   rsp_paddr,
  output logic                rsp_hit,
  output logic                rsp_miss,
  output logic                rsp_fault,
  output logic [2:0]          rsp_code,
  input  logic                wr_en,
  input  logic                wr_kind,
  input  logic [VPN_W-1:0]    wr_vpn,
  input  logic                wr_valid,
  input  logic                wr_present,
  input  logic [FRAME_W-1:0]  wr_data
);
  localparam int SET_W    = $clog2(SETS_PER_SEC);
  localparam int IDX_W    = SEC_W + SET_W;
  localparam int SEG_TAG  = SEG_W - SET_W;
  localparam int PG_TAG   = SEG_W + PAGE_W - SET_W;

  vpn_t rq, wq;
  assign rq = vpn_t'(req_vaddr[ADDR_W-1:OFF_W]);
  assign wq = vpn_t'(wr_vpn);

  // ---- segment descriptor cache ----
  logic              s_hit, s_prs;
  logic [PAGE_W-1:0] s_lim;

  pst_desc_cache #(.IDX_W(IDX_W), .TAG_W(SEG_TAG), .DATA_W(PAGE_W)) u_seg (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(wr_en && !wr_kind),
    .wr_idx({wq.sec, wq.seg[SET_W-1:0]}),
    .wr_tag(wq.seg[SEG_W-1:SET_W]),
    .wr_valid(wr_valid), .wr_present(wr_present),
    .wr_data(wr_data[PAGE_W-1:0]),
    .rd_idx({rq.sec, rq.seg[SET_W-1:0]}),
    .rd_tag(rq.seg[SEG_W-1:SET_W]),
    .rd_hit(s_hit), .rd_present(s_prs), .rd_data(s_lim)
  );

  // ---- page descriptor cache ----
  logic               p_hit, p_prs;
  logic [FRAME_W-1:0] p_frame;

  pst_desc_cache #(.IDX_W(IDX_W), .TAG_W(PG_TAG), .DATA_W(FRAME_W)) u_pg (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(wr_en && wr_kind),
    .wr_idx({wq.sec, wq.page[SET_W-1:0]}),
    .wr_tag({wq.seg, wq.page[PAGE_W-1:SET_W]}),
    .wr_valid(wr_valid), .wr_present(wr_present),
    .wr_data(wr_data),
    .rd_idx({rq.sec, rq.page[SET_W-1:0]}),
    .rd_tag({rq.seg, rq.page[PAGE_W-1:SET_W]}),
    .rd_hit(p_hit), .rd_present(p_prs), .rd_data(p_frame)
  );

  xl_code_e code_d;

  pst_classify u_cls (
    .seg_hit(s_hit), .seg_present(s_prs), .seg_limit(s_lim),
    .page(rq.page), .pg_hit(p_hit), .pg_present(p_prs),
    .code(code_d)
  );

  // ---- result stage ----
  logic               accept;
  xl_code_e           code_q;
  logic [ADDR_W-1:0]  paddr_q;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      code_q    <= XL_SEG_MISS;
      paddr_q   <= '0;
    end else begin
      if (req_ready) rsp_valid <= req_valid;
      if (accept) begin
        code_q  <= code_d;
        paddr_q <= (code_d == XL_HIT) ? {p_frame, req_vaddr[OFF_W-1:0]} : '0;
      end
    end
  end

  assign rsp_code  = code_q;
  assign rsp_paddr = paddr_q;
  assign rsp_hit   = (code_q == XL_HIT);
  assign rsp_miss  = (code_q == XL_SEG_MISS) || (code_q == XL_PAGE_MISS);
  assign rsp_fault = (code_q == XL_SEG_ABSENT) || (code_q == XL_BOUNDS) ||
                     (code_q == XL_PAGE_ABSENT);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid)
    else $error("accepted request produced no result");

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_code)))
    else $error("stalled result changed");

  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1))
    else $error("outcome flags not exclusive");

  assert_zero_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0))
    else $error("address on a non-hit");

  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!rsp_hit || rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])))
    else $error("offset altered");
endmodule

// File: tb/pst_translator_tb.sv
module pst_translator_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_paddr;
  logic        rsp_hit, rsp_miss, rsp_fault;
  logic [2:0]  rsp_code;
  logic        wr_en = 1'b0;
  logic        wr_kind = 1'b0;
  logic [20:0] wr_vpn = '0;
  logic        wr_valid = 1'b0;
  logic        wr_present = 1'b0;
  logic [20:0] wr_data = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pst_translator u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_code(rsp_code),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_vpn(wr_vpn), .wr_valid(wr_valid),
    .wr_present(wr_present), .wr_data(wr_data)
  );

  typedef struct packed {
    logic [31:0] va;
    logic [2:0]  code;
    logic [20:0] frame;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{{2'd1, 13'd5,     6'd3,  11'h7FF}, 3'd0, 21'h12345, 8'd1},  // R1 hit, max offset
    '{{2'd1, 13'd5,     6'd10, 11'h000}, 3'd0, 21'h1ABCD, 8'd6},  // R6 page equals limit
    '{{2'd1, 13'd5,     6'd11, 11'h001}, 3'd3, 21'h0,     8'd6},  // R6 one past limit
    '{{2'd1, 13'd5,     6'd4,  11'h010}, 3'd5, 21'h0,     8'd8},  // R8 page absent
    '{{2'd1, 13'd5,     6'd5,  11'h020}, 3'd4, 21'h0,     8'd7},  // R7 empty page set
    '{{2'd2, 13'h0D,    6'd0,  11'h000}, 3'd2, 21'h0,     8'd5},  // R5 segment absent
    '{{2'd3, 13'd5,     6'd3,  11'h000}, 3'd1, 21'h0,     8'd4},  // R4 other section
    '{{2'd1, 13'h0D,    6'd3,  11'h000}, 3'd1, 21'h0,     8'd4},  // R4 tag mismatch
    '{{2'd0, 13'h1FFF,  6'd63, 11'h123}, 3'd0, 21'h00001, 8'd1},  // R1 top segment/page
    '{{2'd0, 13'h1FFF,  6'd7,  11'h000}, 3'd4, 21'h0,     8'd7},  // R7 page tag mismatch
    '{{2'd0, 13'h1FFF,  6'd3,  11'h000}, 3'd4, 21'h0,     8'd7}   // R7 section in page index
  };

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr_desc(input logic kind, input logic [1:0] sec, input logic [12:0] seg,
                         input logic [5:0] pg, input logic v, input logic p,
                         input logic [20:0] d, input logic with_flush);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = kind; wr_vpn = {sec, seg, pg};
    wr_valid = v; wr_present = p; wr_data = d; flush = with_flush;
    @(negedge clk);
    wr_en = 1'b0; flush = 1'b0;
  endtask

  function automatic logic [63:0] expect_of(input logic [31:0] va, input logic [2:0] code,
                                            input logic [20:0] frame);
    logic h, m, f;
    logic [31:0] pa;
    h  = (code == 3'd0);
    m  = (code == 3'd1) || (code == 3'd4);
    f  = (code == 3'd2) || (code == 3'd3) || (code == 3'd5);
    pa = h ? {frame, va[10:0]} : 32'h0;
    return {26'h0, code, pa, h, m, f};
  endfunction

  function automatic logic [63:0] observed();
    return {26'h0, rsp_code, rsp_paddr, rsp_hit, rsp_miss, rsp_fault};
  endfunction

  task automatic do_req(input string rq, input logic [31:0] va, input logic [2:0] code,
                        input logic [20:0] frame);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2", {63'h0, rsp_valid}, 64'h1);
    chk(rq, observed(), expect_of(va, code, frame));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset", {62'h0, rsp_valid, req_ready}, 64'h1);
    rst_n = 1'b1;

    // descriptors (R11: kind 0 segment, 1 page; data[5:0] is the limit)
    wr_desc(1'b0, 2'd1, 13'd5,    6'd0, 1'b1, 1'b1, 21'd10, 1'b0);
    wr_desc(1'b1, 2'd1, 13'd5,    6'd3, 1'b1, 1'b1, 21'h12345, 1'b0);
    wr_desc(1'b1, 2'd1, 13'd5,    6'd10, 1'b1, 1'b1, 21'h1ABCD, 1'b0);
    wr_desc(1'b1, 2'd1, 13'd5,    6'd4, 1'b1, 1'b0, 21'h0BEEF, 1'b0);
    wr_desc(1'b0, 2'd2, 13'h0D,   6'd0, 1'b1, 1'b0, 21'd63, 1'b0);
    wr_desc(1'b0, 2'd0, 13'h1FFF, 6'd0, 1'b1, 1'b1, 21'd63, 1'b0);
    wr_desc(1'b1, 2'd0, 13'h1FFF, 6'd63, 1'b1, 1'b1, 21'h00001, 1'b0);

    for (int i = 0; i < NV; i++) begin
      do_req($sformatf("R%0d vec%0d", VEC[i].rq, i), VEC[i].va, VEC[i].code, VEC[i].frame);
    end

    // R3 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_vaddr = {2'd1, 13'd5, 6'd3, 11'h0AA};
    @(negedge clk);
    chk("R3 stall ready", {62'h0, rsp_valid, req_ready}, 64'h2);
    req_vaddr = {2'd1, 13'd5, 6'd10, 11'h055};
    @(negedge clk);
    chk("R3 held", observed(), expect_of({2'd1, 13'd5, 6'd3, 11'h0AA}, 3'd0, 21'h12345));
    chk("R3 still stalled", {63'h0, req_ready}, 64'h0);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3 second", observed(), expect_of({2'd1, 13'd5, 6'd10, 11'h055}, 3'd0, 21'h1ABCD));
    @(negedge clk);
    chk("R2 drain", {63'h0, rsp_valid}, 64'h0);

    // R11 invalidate by write, then refill
    wr_desc(1'b0, 2'd1, 13'd5, 6'd0, 1'b0, 1'b1, 21'd10, 1'b0);
    do_req("R11 invalidated", {2'd1, 13'd5, 6'd3, 11'h001}, 3'd1, 21'h0);
    wr_desc(1'b0, 2'd1, 13'd5, 6'd0, 1'b1, 1'b1, 21'd10, 1'b0);
    do_req("R11 refilled", {2'd1, 13'd5, 6'd3, 11'h002}, 3'd0, 21'h12345);

    // R9 priority: segment absent beats bounds (limit 0, page 9)
    wr_desc(1'b0, 2'd3, 13'd2, 6'd0, 1'b1, 1'b0, 21'd0, 1'b0);
    do_req("R9 priority", {2'd3, 13'd2, 6'd9, 11'h000}, 3'd2, 21'h0);

    // R10 flush with a simultaneous write: flush wins
    wr_desc(1'b0, 2'd0, 13'h1FFF, 6'd0, 1'b1, 1'b1, 21'd63, 1'b1);
    do_req("R10 seg flushed", {2'd0, 13'h1FFF, 6'd63, 11'h000}, 3'd1, 21'h0);
    do_req("R10 seg flushed b", {2'd1, 13'd5, 6'd3, 11'h000}, 3'd1, 21'h0);
    wr_desc(1'b0, 2'd0, 13'h1FFF, 6'd0, 1'b1, 1'b1, 21'd63, 1'b0);
    do_req("R10 page flushed", {2'd0, 13'h1FFF, 6'd63, 11'h000}, 3'd4, 21'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule